// File: doc/BRIEF.md
# Row Cache Hit Comparator

This block models the per-bank page cache of a two-bank synchronous DRAM together with the comparator that decides whether a write also updates that cache. Each bank keeps one cached page, filled only by a read command, and a tag holding the row address that was last read from that bank. When a bank is activated, the new row address is compared with that tag and a hit/miss flag is stored for the bank. Writes issued while the row is open consult the flag. On a hit the word goes both to the DRAM array and to the cached page. On a miss only the DRAM array is written.

The commands arrive as already-decoded strobes (activate, read, write, refresh) with a bank select, a row address and a column address. A mode input selects the no-write-transfer mode, which is the only mode in which the comparison is used. In the other mode the hit flag is held low, so writes never reach the cache. The DRAM array is a plain register array. A second, independent read port returns a word from a bank's cached page, which is how reads are served from the cache during refresh. The defaults are scaled down: 16 rows of 8 words of 8 bits per bank. The full-size part (2048 rows, 4096-bit pages) is the same logic with wider parameters.

Top module: `rc_hit_top`

## Requirements
- R1: After a synchronous active-low reset, both hit flags are 0, `rdata_vld` is 0, no bank has an open row, and every cached word reads 0 on the cache port.
- R2: The first activate of a bank after reset always latches a miss (hit flag 0 on the next cycle), whatever the row.
- R3: In no-write-transfer mode (`mode_nwt`=1), an activate latches hit=1 for the selected bank when its row equals the row last read from that bank, and hit=0 otherwise. The other bank's flag is unchanged. `bank`=0 selects `hit[0]` and `bank`=1 selects `hit[1]`.
- R4: A read of an open bank copies the whole open row into that bank's cached page. The word at `col` of that row appears on `rdata`, with `rdata_vld`=1, one cycle after the read.
- R5: A read of an open bank in no-write-transfer mode sets that bank's last-read tag to the open row and sets its hit flag to 1.
- R6: A write to an open bank whose hit flag is 1 stores `wdata` both in the DRAM array and at `col` of the cached page. The cache port shows it the cycle after the write.
- R7: A write to an open bank whose hit flag is 0 stores `wdata` in the DRAM array only, and the cached page keeps its old contents.
- R8: With `mode_nwt`=0, activates and reads leave the selected bank's hit flag at 0, so writes update the DRAM array only.
- R9: A refresh changes neither cached page, tag nor hit flag.
- R10: A read or write to a bank with no open row is ignored: no `rdata_vld`, no DRAM change, no cache change.
- R11: If several strobes are set in one cycle, only one command executes, with priority activate, then read, then write, then refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_nwt | input | 1 | 1 = no-write-transfer mode (comparison enabled) |
| act_en | input | 1 | Activate strobe |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| ref_en | input | 1 | Auto refresh strobe |
| bank | input | BANK_W | Bank select for the command |
| row | input | ROW_W | Row address for activate |
| col | input | COL_W | Column address for read and write |
| wdata | input | DATA_W | Write data |
| peek_bank | input | BANK_W | Bank for the cache read port |
| peek_col | input | COL_W | Column for the cache read port |
| rdata | output | DATA_W | Read data, valid one cycle after a read |
| rdata_vld | output | 1 | Read data valid |
| peek_data | output | DATA_W | Cached word at peek_bank/peek_col |
| hit | output | 2**BANK_W | Per-bank latched hit flag |

## Verification
The comparator is tried with five activate patterns. An activate of an untagged bank checks the reset miss. Re-opening the last-read row gives a hit. Opening a different row gives a miss. Opening the same row in the other bank shows that the tags are kept per bank. An activate after a later read has moved the tag shows that the tag follows reads rather than activates. Writes are issued under both hit and miss, and the cache port and a later DRAM read are compared with each other to separate write-through from DRAM-only writes. Refresh, write-transfer mode, commands to closed banks and stacked strobes are each shown to leave the cache port and the flags unchanged, or to execute only the winning command.

// File: rtl/rc_pkg.sv
// Shared types for the row cache hit comparator.
// Assumes at most one decoded command is acted on per cycle.
package rc_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_REF = 3'd4
    } rc_cmd_e;
endpackage

// File: rtl/rc_cmd_decode.sv
// Turns the four command strobes into one command code.
// Assumes the strobes may overlap; activate wins, then read, write, refresh.
module rc_cmd_decode
    import rc_pkg::*;
(
    input  logic    act_en,
    input  logic    rd_en,
    input  logic    wr_en,
    input  logic    ref_en,
    output rc_cmd_e cmd
);
    // Priority pick of the command for this cycle.
    always_comb begin
        if (act_en)      cmd = CMD_ACT;
        else if (rd_en)  cmd = CMD_RD;
        else if (wr_en)  cmd = CMD_WR;
        else if (ref_en) cmd = CMD_REF;
        else             cmd = CMD_NOP;
    end

    // R11: exactly one command code is produced whenever any strobe is set.
    always_comb begin
        if (act_en) a_act_wins_r11: assert (cmd == CMD_ACT);
    end
endmodule

// File: rtl/rc_bank_tag.sv
// Per-bank open-row register, last-read tag and hit/miss flag.
// Assumes sel is high only when the command addresses this bank.
// The tag is invalid after reset, so the first activate always misses.
module rc_bank_tag
    import rc_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_nwt,
    input  rc_cmd_e          cmd,
    input  logic             sel,
    input  logic [ROW_W-1:0] row,
    output logic             open_vld,
    output logic [ROW_W-1:0] open_row,
    output logic             hit
);
    logic             tag_vld;
    logic [ROW_W-1:0] tag_row;

    // Track the open row, the last-read row and the latched compare result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld <= 1'b0;
            open_row <= '0;
            tag_vld  <= 1'b0;
            tag_row  <= '0;
            hit      <= 1'b0;
        end else if (sel) begin
            case (cmd)
                CMD_ACT: begin
                    open_vld <= 1'b1;
                    open_row <= row;
                    hit      <= mode_nwt && tag_vld && (tag_row == row);
                end
                CMD_RD: begin
                    if (open_vld) begin
                        tag_vld <= 1'b1;
                        tag_row <= open_row;
                        hit     <= mode_nwt;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: an activate on an untagged bank reports a miss.
    p_untagged_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == CMD_ACT && !tag_vld) |=> !hit);

    // R3: a hit can only exist against a valid last-read tag.
    p_hit_has_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> tag_vld);

    // R5: a read of the open row retags the bank and raises the flag.
    p_read_retags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cmd == CMD_RD && open_vld && mode_nwt) |=>
            (hit && tag_vld && tag_row == open_row));

    // R8: outside no-write-transfer mode the flag stays low.
    p_wt_mode_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !mode_nwt && (cmd == CMD_ACT || cmd == CMD_RD)) |=> !hit);

    // R9: refresh leaves tag and flag alone.
    p_refresh_keeps_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |=> ($stable(hit) && $stable(tag_row) && $stable(tag_vld)));
endmodule

// File: rtl/rc_dram_array.sv
// Register model of the DRAM array for all banks.
// Provides one word write port, a combinational page read of one row,
// and a registered word read with a valid strobe.
module rc_dram_array #(
    parameter int BANK_W = 1,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [BANK_W-1:0]        wr_bank,
    input  logic [ROW_W-1:0]         wr_row,
    input  logic [COL_W-1:0]         wr_col,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [BANK_W-1:0]        pg_bank,
    input  logic [ROW_W-1:0]         pg_row,
    output logic [(2**COL_W)*DATA_W-1:0] page,
    input  logic                     rd,
    input  logic [COL_W-1:0]         rd_col,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_vld
);
    localparam int NBANK = 2 ** BANK_W;
    localparam int ROWS  = 2 ** ROW_W;
    localparam int COLS  = 2 ** COL_W;

    logic [DATA_W-1:0] mem [NBANK][ROWS][COLS];

    // Array storage: cleared on reset, one word written per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBANK; b++)
                for (int r = 0; r < ROWS; r++)
                    for (int c = 0; c < COLS; c++)
                        mem[b][r][c] <= '0;
        end else if (wr) begin
            mem[wr_bank][wr_row][wr_col] <= wdata;
        end
    end

    // Present the addressed row as one flat page.
    always_comb begin
        for (int c = 0; c < COLS; c++)
            page[c*DATA_W +: DATA_W] = mem[pg_bank][pg_row][c];
    end

    // Registered word read out of the addressed page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            rdata_vld <= rd;
            if (rd) rdata <= page[rd_col*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/rc_row_cache.sv
// One bank's cached page. Loaded whole from a DRAM page on a read,
// patched one word at a time by write-through, read by a side port.
// Assumes load and wr are never high together.
module rc_row_cache #(
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [(2**COL_W)*DATA_W-1:0] page_in,
    input  logic                         wr,
    input  logic [COL_W-1:0]             col,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [COL_W-1:0]             peek_col,
    output logic [DATA_W-1:0]            peek_data,
    output logic [(2**COL_W)*DATA_W-1:0] page_out
);
    localparam int COLS = 2 ** COL_W;

    logic [DATA_W-1:0] words [COLS];

    // Page storage: whole-page load on read, single word on write-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++) words[c] <= '0;
        end else if (load) begin
            for (int c = 0; c < COLS; c++) words[c] <= page_in[c*DATA_W +: DATA_W];
        end else if (wr) begin
            words[col] <= wdata;
        end
    end

    // Side read port and flat view of the page.
    assign peek_data = words[peek_col];
    always_comb begin
        for (int c = 0; c < COLS; c++) page_out[c*DATA_W +: DATA_W] = words[c];
    end

    // R6: a write-through lands in the addressed word on the next cycle.
    p_wr_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !load) |=> (words[$past(col)] == $past(wdata)));
endmodule

// File: rtl/rc_hit_top.sv
// Row cache with write-transfer hit logic for a multi-bank DRAM model.
// Decodes the command strobes, keeps per-bank tags and hit flags,
// routes reads into the cache and writes into DRAM and, on a hit, the cache.
// Assumes the caller issues legal sequences; a read or write to a bank
// with no open row is dropped.
module rc_hit_top
    import rc_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_nwt,
    input  logic                  act_en,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic                  ref_en,
    input  logic [BANK_W-1:0]     bank,
    input  logic [ROW_W-1:0]      row,
    input  logic [COL_W-1:0]      col,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [BANK_W-1:0]     peek_bank,
    input  logic [COL_W-1:0]      peek_col,
    output logic [DATA_W-1:0]     rdata,
    output logic                  rdata_vld,
    output logic [DATA_W-1:0]     peek_data,
    output logic [(2**BANK_W)-1:0] hit
);
    localparam int NBANK  = 2 ** BANK_W;
    localparam int COLS   = 2 ** COL_W;
    localparam int PAGE_W = COLS * DATA_W;

    rc_cmd_e           cmd;
    logic [NBANK-1:0]  open_vld;
    logic [ROW_W-1:0]  open_row [NBANK];
    logic [PAGE_W-1:0] cpage    [NBANK];
    logic [DATA_W-1:0] peek_a   [NBANK];
    logic [PAGE_W-1:0] dram_page;
    logic              rd_fire;
    logic              wr_fire;

    rc_cmd_decode u_dec (
        .act_en (act_en),
        .rd_en  (rd_en),
        .wr_en  (wr_en),
        .ref_en (ref_en),
        .cmd    (cmd)
    );

    // Reads and writes only act on a bank with an open row.
    assign rd_fire = (cmd == CMD_RD) && open_vld[bank];
    assign wr_fire = (cmd == CMD_WR) && open_vld[bank];

    rc_dram_array #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_dram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_fire),
        .wr_bank   (bank),
        .wr_row    (open_row[bank]),
        .wr_col    (col),
        .wdata     (wdata),
        .pg_bank   (bank),
        .pg_row    (open_row[bank]),
        .page      (dram_page),
        .rd        (rd_fire),
        .rd_col    (col),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel;
        assign sel = (bank == BANK_W'(b));

        rc_bank_tag #(.ROW_W(ROW_W)) u_tag (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_nwt (mode_nwt),
            .cmd      (cmd),
            .sel      (sel),
            .row      (row),
            .open_vld (open_vld[b]),
            .open_row (open_row[b]),
            .hit      (hit[b])
        );

        rc_row_cache #(.COL_W(COL_W), .DATA_W(DATA_W)) u_cache (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (rd_fire && sel),
            .page_in   (dram_page),
            .wr        (wr_fire && sel && hit[b]),
            .col       (col),
            .wdata     (wdata),
            .peek_col  (peek_col),
            .peek_data (peek_a[b]),
            .page_out  (cpage[b])
        );

        // R7: a write with the flag low leaves this bank's page untouched.
        p_miss_write_keeps_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_WR && sel && !hit[b]) |=> $stable(cpage[b]));

        // R9: refresh leaves every cached page untouched.
        p_refresh_keeps_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_REF) |=> $stable(cpage[b]));

        // R10: commands to a closed bank leave its page untouched.
        p_closed_keeps_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd == CMD_RD || cmd == CMD_WR) && sel && !open_vld[b]) |=> $stable(cpage[b]));
    end

    // Cache side port mux.
    assign peek_data = peek_a[peek_bank];

    // R4: a read of an open bank yields data on the next cycle.
    p_read_gives_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rdata_vld);

    // R10: a read of a closed bank produces no data strobe.
    p_closed_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD && !open_vld[bank]) |=> !rdata_vld);
endmodule

// File: tb/rc_hit_top_test.sv
module rc_hit_top_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_nwt;
    logic       act_en, rd_en, wr_en, ref_en;
    logic [0:0] bank, peek_bank;
    logic [3:0] row;
    logic [2:0] col, peek_col;
    logic [7:0] wdata, rdata, peek_data;
    logic       rdata_vld;
    logic [1:0] hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rc_hit_top uut (
        .clk(clk), .rst_n(rst_n), .mode_nwt(mode_nwt),
        .act_en(act_en), .rd_en(rd_en), .wr_en(wr_en), .ref_en(ref_en),
        .bank(bank), .row(row), .col(col), .wdata(wdata),
        .peek_bank(peek_bank), .peek_col(peek_col),
        .rdata(rdata), .rdata_vld(rdata_vld), .peek_data(peek_data), .hit(hit)
    );

    // op codes: 0 nop, 1 activate, 2 read, 3 write, 4 refresh
    // entry: op[29:27] bank[26] row[25:22] col[21:19] data[18:11]
    //        exp_hit[10:9] chk_rd[8] exp_rd[7:0]
    localparam int NV = 14;
    localparam logic [29:0] VEC [NV] = '{
        {3'd1, 1'b0, 4'd3, 3'd0, 8'h00, 2'b00, 1'b0, 8'h00}, // R2 untagged miss
        {3'd3, 1'b0, 4'd0, 3'd2, 8'hA5, 2'b00, 1'b0, 8'h00}, // R7 miss write
        {3'd2, 1'b0, 4'd0, 3'd2, 8'h00, 2'b01, 1'b1, 8'hA5}, // R4 R5 read
        {3'd3, 1'b0, 4'd0, 3'd5, 8'h3C, 2'b01, 1'b0, 8'h00}, // R6 hit write
        {3'd1, 1'b1, 4'd3, 3'd0, 8'h00, 2'b01, 1'b0, 8'h00}, // R3 per-bank tag
        {3'd2, 1'b1, 4'd0, 3'd0, 8'h00, 2'b11, 1'b1, 8'h00}, // R5 bank 1
        {3'd4, 1'b0, 4'd0, 3'd0, 8'h00, 2'b11, 1'b0, 8'h00}, // R9 refresh
        {3'd1, 1'b0, 4'd7, 3'd0, 8'h00, 2'b10, 1'b0, 8'h00}, // R3 other row miss
        {3'd3, 1'b0, 4'd0, 3'd5, 8'h77, 2'b10, 1'b0, 8'h00}, // R7 DRAM only
        {3'd1, 1'b0, 4'd3, 3'd0, 8'h00, 2'b11, 1'b0, 8'h00}, // R3 back to read row
        {3'd2, 1'b0, 4'd0, 3'd5, 8'h00, 2'b11, 1'b1, 8'h3C}, // R4 R6
        {3'd1, 1'b0, 4'd7, 3'd0, 8'h00, 2'b10, 1'b0, 8'h00}, // R3 miss
        {3'd2, 1'b0, 4'd0, 3'd5, 8'h00, 2'b11, 1'b1, 8'h77}, // R4 R7 DRAM got it
        {3'd1, 1'b0, 4'd3, 3'd0, 8'h00, 2'b10, 1'b0, 8'h00}  // R3 tag moved to 7
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        act_en = 0; rd_en = 0; wr_en = 0; ref_en = 0;
    endtask

    // Drive one command for one cycle; return at the following negedge.
    task automatic run_op(input logic [2:0] op, input logic b, input logic [3:0] r,
                          input logic [2:0] c, input logic [7:0] d);
        @(negedge clk);
        act_en = (op == 3'd1); rd_en = (op == 3'd2);
        wr_en  = (op == 3'd3); ref_en = (op == 3'd4);
        bank = b; row = r; col = c; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_nwt = 1; idle();
        bank = 0; row = 0; col = 0; wdata = 0; peek_bank = 0; peek_col = 0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 hit", {6'b0, hit}, 8'h00);
        check("R1 rdata_vld", {7'b0, rdata_vld}, 8'h00);
        peek_bank = 1; peek_col = 6; #1;
        check("R1 cache cleared", peek_data, 8'h00);

        // Table walk (R2..R7, R9)
        for (int i = 0; i < NV; i++) begin
            logic [29:0] v;
            v = VEC[i];
            run_op(v[29:27], v[26], v[25:22], v[21:19], v[18:11]);
            check($sformatf("R3 hit flags step %0d", i), {6'b0, hit}, {6'b0, v[10:9]});
            if (v[8]) begin
                check($sformatf("R4 rdata_vld step %0d", i), {7'b0, rdata_vld}, 8'h01);
                check($sformatf("R4 rdata step %0d", i), rdata, v[7:0]);
            end
        end

        // R6: hit write shows on the cache port
        run_op(3'd1, 1'b0, 4'd7, 3'd0, 8'h00);   // tag is 7 -> hit
        check("R6 hit before write", {7'b0, hit[0]}, 8'h01);
        run_op(3'd3, 1'b0, 4'd0, 3'd1, 8'hE1);
        peek_bank = 0; peek_col = 1; #1;
        check("R6 cache written", peek_data, 8'hE1);

        // R7: miss write leaves cache, reaches DRAM
        run_op(3'd1, 1'b0, 4'd2, 3'd0, 8'h00);
        run_op(3'd3, 1'b0, 4'd0, 3'd1, 8'hF0);
        #1;
        check("R7 cache unchanged", peek_data, 8'hE1);
        run_op(3'd2, 1'b0, 4'd0, 3'd1, 8'h00);
        check("R7 DRAM written", rdata, 8'hF0);
        #1;
        check("R4 cache reloaded by read", peek_data, 8'hF0);

        // R9: refresh keeps cache contents
        run_op(3'd4, 1'b0, 4'd0, 3'd0, 8'h00);
        #1;
        check("R9 cache kept", peek_data, 8'hF0);
        check("R9 flags kept", {6'b0, hit}, 8'h03);

        // R8: write-transfer mode
        mode_nwt = 0;
        run_op(3'd1, 1'b1, 4'd3, 3'd0, 8'h00);  // same row as bank 1 tag
        check("R8 activate no hit", {7'b0, hit[1]}, 8'h00);
        run_op(3'd2, 1'b1, 4'd0, 3'd4, 8'h00);
        check("R8 read no hit", {7'b0, hit[1]}, 8'h00);
        run_op(3'd3, 1'b1, 4'd0, 3'd4, 8'h99);
        peek_bank = 1; peek_col = 4; #1;
        check("R8 cache untouched", peek_data, 8'h00);
        run_op(3'd2, 1'b1, 4'd0, 3'd4, 8'h00);
        check("R8 DRAM written", rdata, 8'h99);
        mode_nwt = 1;

        // R11: stacked strobes, activate wins over read
        @(negedge clk);
        act_en = 1; rd_en = 1; bank = 0; row = 4'd9; col = 0;
        @(negedge clk);
        idle();
        check("R11 read suppressed", {7'b0, rdata_vld}, 8'h00);
        // R11: read wins over write
        @(negedge clk);
        rd_en = 1; wr_en = 1; bank = 0; col = 3'd3; wdata = 8'h5A;
        @(negedge clk);
        idle();
        check("R11 read executed", {7'b0, rdata_vld}, 8'h01);
        run_op(3'd2, 1'b0, 4'd0, 3'd3, 8'h00);
        check("R11 write suppressed", rdata, 8'h00);

        // R10: closed bank after a second reset
        do_reset();
        run_op(3'd2, 1'b0, 4'd0, 3'd0, 8'h00);
        check("R10 no data from closed bank", {7'b0, rdata_vld}, 8'h00);
        run_op(3'd3, 1'b0, 4'd0, 3'd0, 8'h11);
        peek_bank = 0; peek_col = 0; #1;
        check("R10 cache untouched", peek_data, 8'h00);
        run_op(3'd1, 1'b0, 4'd0, 3'd0, 8'h00);
        check("R2 miss after reset", {6'b0, hit}, 8'h00);
        run_op(3'd2, 1'b0, 4'd0, 3'd0, 8'h00);
        check("R10 DRAM untouched", rdata, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule